// File: doc/BRIEF.md
# Backplane fast-control command translator

This block sits between the crate backplane and the board's internal fast-control bus. It samples the active-low backplane timing lines on the 40 MHz system clock: a 6-bit command bus with its strobe, a level-1 accept line, an event-counter-reset line and a ready line. It drives a 6-bit internal bus. Bits [2:0] of that bus carry a compressed broadcast code. Bit 3 is the SF run line, bit 4 is the TF run line and bit 5 is the internal level-1 accept. Every bus value is a one-cycle registered pulse.

A small configuration/status word controls the block. It selects whether the bus follows the backplane or is under VME control, and it gates the two run lines. It can also replace the backplane accept with a fake accept that is made from the SF run line, which helps when testing readout. The word reads back four FMM state flags. While under VME control the bus shows the "VME control" code, and a local inject strobe can place any chosen bus value for a single cycle.

Top module: `fcbus_xlate`

## Requirements
- R1: All backplane inputs are active low and are inverted before use. In backplane mode, a value present on the inputs before clock edge k appears on `fc_cmd` after edge k+1, which is a latency of two cycles.
- R2: In backplane mode, when the ready line is high (not asserted), `fc_cmd` is 0x00 whatever the other backplane lines carry.
- R3: In backplane mode with ready asserted, a command is decoded only in a cycle where its strobe is asserted. The encoded field `fc_cmd[2:0]` is set as follows: command 0x00 gives 0, 0x01 gives 1, 0x02 gives 2, 0x03 gives 3, 0x06 gives 5 and 0x07 gives 6. Every other command, and any cycle without a strobe, gives 0.
- R4: In backplane mode with ready asserted, an asserted event-counter-reset line sets `fc_cmd[2:0]` to 4. This takes priority over any strobed command code.
- R5: In backplane mode, the strobed commands 0x2F and 0x01 raise `fc_cmd[4]` if config bit 1 (TF enable) is 1, and raise `fc_cmd[3]` if config bit 0 (SF enable) is 1. The commands 0x24 and 0x30 raise only `fc_cmd[3]`, and only if config bit 0 is 1. No other command raises either bit.
- R6: In backplane mode, `fc_cmd[5]` follows the backplane accept line when config bit 5 (fake accept) is 0. When bit 5 is 1, the backplane accept is ignored and `fc_cmd[5]` equals `fc_cmd[3]` of the same cycle.
- R7: When config bit 8 (VME mode) is 1, `fc_cmd` is 0x07 in every cycle without an inject, and all backplane inputs are ignored. Code 7 never appears in `fc_cmd[2:0]` in backplane mode.
- R8: In VME mode, an `inj_wr` pulse puts `inj_code` on `fc_cmd` one cycle later, for one cycle. In backplane mode `inj_wr` has no effect.
- R9: Writes update only config bits 8, 5, 4, 1 and 0. After reset the word reads 0x0100 ORed with the flags. Bits 15..12 read `fmm_flags[3:0]` (Ready, Busy, Out-of-Sync, Warning-Overflow) and cannot be written. All other bits read 0. `lct_en` equals config bit 4.
- R10: After reset, `fc_cmd` reads 0x07, and a single-cycle backplane input produces a single-cycle bus value, followed by the idle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bp_cmd_n | input | 6 | Backplane command bus, active low |
| bp_cmd_str_n | input | 1 | Command strobe, active low |
| bp_l1a_n | input | 1 | Backplane level-1 accept, active low |
| bp_ecr_n | input | 1 | Event-counter-reset line, active low |
| bp_rdy_n | input | 1 | Backplane ready, active low |
| reg_wr | input | 1 | Configuration word write strobe |
| reg_wdata | input | 16 | Configuration write data |
| reg_rdata | output | 16 | Configuration/status read data |
| fmm_flags | input | 4 | FMM flags: [3] Ready, [2] Busy, [1] Out-of-Sync, [0] Warning-Overflow |
| inj_wr | input | 1 | Inject strobe (VME mode only) |
| inj_code | input | 6 | Bus value to inject |
| fc_cmd | output | 6 | Internal fast-control bus |
| lct_en | output | 1 | Local trigger request enable |

## Verification
The bench sweeps all 64 command values under all eight combinations of the two run enables and the fake-accept bit. It catches a design that mis-maps an unlisted code, gates the wrong run line, or lets a backplane accept leak through while the fake accept is selected. Directed cases pit the event-counter-reset line against a strobed command, and present commands without a strobe or without ready. A design with the wrong priority, or one that decodes without the qualifiers, shows a non-zero or wrong code in those cases. VME-mode cases check that backplane traffic is hidden behind code 7 and that an inject lasts exactly one cycle. A sweep of the flags together with an all-ones write exposes writable read-only bits and bits that should read 0.

// File: rtl/fcx_pkg.sv
package fcx_pkg;
    localparam int CMD_W  = 6;
    localparam int CODE_W = 3;
    localparam int FC_W   = CODE_W + 3;
    localparam int REG_W  = 16;
    localparam int FLAG_W = 4;

    localparam int B_FCM = 8;
    localparam int B_FCL = 5;
    localparam int B_LCT = 4;
    localparam int B_TFE = 1;
    localparam int B_SFE = 0;
    localparam int B_FLAG_LO = REG_W - FLAG_W;

    localparam logic [CMD_W-1:0] BP_NOCMD = 6'h00;
    localparam logic [CMD_W-1:0] BP_BC0   = 6'h01;
    localparam logic [CMD_W-1:0] BP_OCRES = 6'h02;
    localparam logic [CMD_W-1:0] BP_RSYNC = 6'h03;
    localparam logic [CMD_W-1:0] BP_START = 6'h06;
    localparam logic [CMD_W-1:0] BP_STOP  = 6'h07;
    localparam logic [CMD_W-1:0] BP_TPSP  = 6'h2F;
    localparam logic [CMD_W-1:0] BP_TPTMB = 6'h24;
    localparam logic [CMD_W-1:0] BP_TPMPC = 6'h30;

    localparam logic [CODE_W-1:0] FC_NONE  = 3'd0;
    localparam logic [CODE_W-1:0] FC_BC0   = 3'd1;
    localparam logic [CODE_W-1:0] FC_OCRES = 3'd2;
    localparam logic [CODE_W-1:0] FC_RSYNC = 3'd3;
    localparam logic [CODE_W-1:0] FC_ECRES = 3'd4;
    localparam logic [CODE_W-1:0] FC_START = 3'd5;
    localparam logic [CODE_W-1:0] FC_STOP  = 3'd6;
    localparam logic [CODE_W-1:0] FC_VME   = 3'd7;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic             str;
        logic             l1a;
        logic             ecr;
        logic             rdy;
    } bp_t;

    typedef struct packed {
        logic fcm;
        logic fcl;
        logic lct;
        logic tfe;
        logic sfe;
    } cfg_t;

    typedef struct packed {
        logic              l1a;
        logic              tf;
        logic              sf;
        logic [CODE_W-1:0] code;
    } fc_t;
endpackage

// File: rtl/fcx_sampler.sv
module fcx_sampler
    import fcx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] cmd_n,
    input  logic             str_n,
    input  logic             l1a_n,
    input  logic             ecr_n,
    input  logic             rdy_n,
    output bp_t              bp
);
    bp_t bp_d, bp_q;

    always_comb begin
        bp_d.cmd = ~cmd_n;
        bp_d.str = ~str_n;
        bp_d.l1a = ~l1a_n;
        bp_d.ecr = ~ecr_n;
        bp_d.rdy = ~rdy_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bp_q <= '0;
        else        bp_q <= bp_d;
    end

    assign bp = bp_q;
endmodule

// File: rtl/fcx_cfg.sv
module fcx_cfg
    import fcx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [FLAG_W-1:0] flags,
    output cfg_t              cfg,
    output logic [REG_W-1:0]  rdata
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            cfg_d.fcm = wdata[B_FCM];
            cfg_d.fcl = wdata[B_FCL];
            cfg_d.lct = wdata[B_LCT];
            cfg_d.tfe = wdata[B_TFE];
            cfg_d.sfe = wdata[B_SFE];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            cfg_q.fcm <= 1'b1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata        = '0;
        rdata[B_FCM] = cfg_q.fcm;
        rdata[B_FCL] = cfg_q.fcl;
        rdata[B_LCT] = cfg_q.lct;
        rdata[B_TFE] = cfg_q.tfe;
        rdata[B_SFE] = cfg_q.sfe;
        for (int i = 0; i < FLAG_W; i++) begin
            rdata[B_FLAG_LO+i] = flags[i];
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/fcx_decode.sv
module fcx_decode
    import fcx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  bp_t             bp,
    input  cfg_t            cfg,
    input  logic            inj_wr,
    input  logic [FC_W-1:0] inj_code,
    output logic [FC_W-1:0] fc
);
    fc_t fc_d, fc_q;

    always_comb begin
        fc_d = '0;
        if (cfg.fcm) begin
            fc_d.code = FC_VME;
            if (inj_wr) fc_d = fc_t'(inj_code);
        end else if (bp.rdy) begin
            if (bp.str) begin
                unique case (bp.cmd)
                    BP_NOCMD: fc_d.code = FC_NONE;
                    BP_BC0: begin
                        fc_d.code = FC_BC0;
                        fc_d.tf   = cfg.tfe;
                        fc_d.sf   = cfg.sfe;
                    end
                    BP_OCRES: fc_d.code = FC_OCRES;
                    BP_RSYNC: fc_d.code = FC_RSYNC;
                    BP_START: fc_d.code = FC_START;
                    BP_STOP:  fc_d.code = FC_STOP;
                    BP_TPSP: begin
                        fc_d.tf = cfg.tfe;
                        fc_d.sf = cfg.sfe;
                    end
                    BP_TPTMB, BP_TPMPC: fc_d.sf = cfg.sfe;
                    default: fc_d.code = FC_NONE;
                endcase
            end
            if (bp.ecr) fc_d.code = FC_ECRES;
            fc_d.l1a = cfg.fcl ? fc_d.sf : bp.l1a;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fc_q      <= '0;
            fc_q.code <= FC_VME;
        end else begin
            fc_q <= fc_d;
        end
    end

    assign fc = fc_q;
endmodule

// File: rtl/fcbus_xlate.sv
module fcbus_xlate
    import fcx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  bp_cmd_n,
    input  logic              bp_cmd_str_n,
    input  logic              bp_l1a_n,
    input  logic              bp_ecr_n,
    input  logic              bp_rdy_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [FLAG_W-1:0] fmm_flags,
    input  logic              inj_wr,
    input  logic [FC_W-1:0]   inj_code,
    output logic [FC_W-1:0]   fc_cmd,
    output logic              lct_en
);
    bp_t  bp;
    cfg_t cfg;

    fcx_sampler u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd_n (bp_cmd_n),
        .str_n (bp_cmd_str_n),
        .l1a_n (bp_l1a_n),
        .ecr_n (bp_ecr_n),
        .rdy_n (bp_rdy_n),
        .bp    (bp)
    );

    fcx_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .flags (fmm_flags),
        .cfg   (cfg),
        .rdata (reg_rdata)
    );

    fcx_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .bp       (bp),
        .cfg      (cfg),
        .inj_wr   (inj_wr),
        .inj_code (inj_code),
        .fc       (fc_cmd)
    );

    assign lct_en = cfg.lct;
endmodule

// File: rtl/fcbus_xlate_chk.sv
module fcbus_xlate_chk
    import fcx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bp_l1a_n,
    input logic              bp_rdy_n,
    input logic              inj_wr,
    input logic [FC_W-1:0]   inj_code,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [FC_W-1:0]   fc_cmd
);
    AST_NOT_READY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(reg_rdata[B_FCM]) && $past(bp_rdy_n, 2)) |-> (fc_cmd == '0)); // R2

    AST_L1A_FOLLOWS_BP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(reg_rdata[B_FCM]) && !$past(reg_rdata[B_FCL]) && !$past(bp_rdy_n, 2))
        |-> (fc_cmd[5] == !$past(bp_l1a_n, 2))); // R6

    AST_FAKE_L1A_FROM_SF: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(reg_rdata[B_FCM]) && $past(reg_rdata[B_FCL])) |-> (fc_cmd[5] == fc_cmd[3])); // R6

    AST_VME_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_rdata[B_FCM]) && !$past(inj_wr)) |-> (fc_cmd == 6'h07)); // R7

    AST_NO_VME_CODE_IN_BP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_rdata[B_FCM]) |-> (fc_cmd[2:0] != FC_VME)); // R7

    AST_INJECT_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_rdata[B_FCM]) && $past(inj_wr)) |-> (fc_cmd == $past(inj_code))); // R8
endmodule

bind fcbus_xlate fcbus_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bp_l1a_n  (bp_l1a_n),
    .bp_rdy_n  (bp_rdy_n),
    .inj_wr    (inj_wr),
    .inj_code  (inj_code),
    .reg_rdata (reg_rdata),
    .fc_cmd    (fc_cmd)
);

// File: tb/fcbus_xlate_bench.sv
`timescale 1ns/1ps
module fcbus_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  bp_cmd_n;
    logic        bp_cmd_str_n, bp_l1a_n, bp_ecr_n, bp_rdy_n;
    logic        reg_wr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic [3:0]  fmm_flags;
    logic        inj_wr;
    logic [5:0]  inj_code;
    logic [5:0]  fc_cmd;
    logic        lct_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fcbus_xlate u_fcbus_xlate (
        .clk(clk), .rst_n(rst_n),
        .bp_cmd_n(bp_cmd_n), .bp_cmd_str_n(bp_cmd_str_n), .bp_l1a_n(bp_l1a_n),
        .bp_ecr_n(bp_ecr_n), .bp_rdy_n(bp_rdy_n),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fmm_flags(fmm_flags), .inj_wr(inj_wr), .inj_code(inj_code),
        .fc_cmd(fc_cmd), .lct_en(lct_en)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] model(input logic [5:0] c, input bit s, input bit l,
                                         input bit e, input bit r, input bit tfe,
                                         input bit sfe, input bit fcl);
        logic [2:0] code = 3'd0;
        bit tf = 0, sf = 0, a;
        if (!r) return 6'h00;
        if (s) begin
            if (c == 6'h01) code = 3'd1;
            if (c == 6'h02) code = 3'd2;
            if (c == 6'h03) code = 3'd3;
            if (c == 6'h06) code = 3'd5;
            if (c == 6'h07) code = 3'd6;
            if (c == 6'h01 || c == 6'h2F) begin tf = tfe; sf = sfe; end
            if (c == 6'h24 || c == 6'h30) sf = sfe;
        end
        if (e) code = 3'd4;
        a = fcl ? sf : l;
        return {a, tf, sf, code};
    endfunction

    task automatic idle_inputs();
        bp_cmd_n = 6'h3F; bp_cmd_str_n = 1'b1; bp_l1a_n = 1'b1;
        bp_ecr_n = 1'b1;  bp_rdy_n = 1'b1;
    endtask

    task automatic wr_cfg(input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run(input string req, input logic [5:0] c, input bit s, input bit l,
                       input bit e, input bit r, input logic [5:0] exp, input logic [5:0] idle);
        @(negedge clk);
        bp_cmd_n = ~c; bp_cmd_str_n = ~s; bp_l1a_n = ~l; bp_ecr_n = ~e; bp_rdy_n = ~r;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        chk(req, {10'h0, fc_cmd}, {10'h0, exp});
        @(negedge clk);
        chk("R10 pulse ends", {10'h0, fc_cmd}, {10'h0, idle});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; fmm_flags = 4'h0;
        inj_wr = 1'b0; inj_code = '0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset value", reg_rdata, 16'h0100);
        chk("R10 reset bus", {10'h0, fc_cmd}, 16'h0007);
        chk("R9 lct reset", {15'h0, lct_en}, 16'h0000);

        // R7: VME mode hides backplane traffic
        run("R7 vme ignores bp", 6'h03, 1, 1, 1, 1, 6'h07, 6'h07);
        run("R7 vme ignores bc0", 6'h01, 1, 0, 0, 1, 6'h07, 6'h07);

        // R8: inject in VME mode
        @(negedge clk); inj_wr = 1'b1; inj_code = 6'h2A;
        @(negedge clk); inj_wr = 1'b0;
        chk("R8 inject value", {10'h0, fc_cmd}, 16'h002A);
        @(negedge clk);
        chk("R8 inject one cycle", {10'h0, fc_cmd}, 16'h0007);

        // R9: register fields and flags
        wr_cfg(16'hFFFF);
        chk("R9 all-ones write", reg_rdata, 16'h0133);
        chk("R9 lct_en", {15'h0, lct_en}, 16'h0001);
        for (int f = 0; f < 16; f++) begin
            fmm_flags = 4'(f);
            #1;
            chk("R9 flags", reg_rdata, {4'(f), 12'h133});
        end
        fmm_flags = 4'h0;

        // R3 R5 R6 R1: sweep commands under every enable/fake-accept setting
        for (int cf = 0; cf < 8; cf++) begin
            bit sfe = cf[0], tfe = cf[1], fcl = cf[2];
            wr_cfg({10'h0, fcl, 3'b000, tfe, sfe});
            for (int c = 0; c < 64; c++) begin
                bit l = c[1] ^ c[4];
                run("R3 R5 R6 sweep", 6'(c), 1, l, 0, 1,
                    model(6'(c), 1, l, 0, 1, tfe, sfe, fcl), 6'h00);
            end
        end

        // backplane mode, both runs enabled, real accept
        wr_cfg(16'h0003);
        // R8: inject ignored in backplane mode
        @(negedge clk); inj_wr = 1'b1; inj_code = 6'h3F;
        @(negedge clk); inj_wr = 1'b0;
        chk("R8 inject ignored in bp", {10'h0, fc_cmd}, 16'h0000);
        // R1: accept alone
        run("R1 accept latency", 6'h00, 0, 1, 0, 1, 6'h20, 6'h00);
        // R3: no strobe
        run("R3 no strobe", 6'h02, 0, 0, 0, 1, 6'h00, 6'h00);
        run("R3 no strobe bc0", 6'h01, 0, 0, 0, 1, 6'h00, 6'h00);
        // R4: ecr alone and with command
        run("R4 ecr alone", 6'h00, 0, 0, 1, 1, 6'h04, 6'h00);
        run("R4 ecr over stop", 6'h07, 1, 0, 1, 1, 6'h04, 6'h00);
        run("R4 ecr with bc0 runs", 6'h01, 1, 1, 1, 1, 6'h3C, 6'h00);
        // R2: not ready
        run("R2 not ready", 6'h01, 1, 1, 1, 0, 6'h00, 6'h00);
        run("R2 not ready tpsp", 6'h2F, 1, 0, 0, 0, 6'h00, 6'h00);
        // R6: fake accept ignores backplane accept
        wr_cfg(16'h0021);
        run("R6 fake ignores bp accept", 6'h00, 0, 1, 0, 1, 6'h00, 6'h00);
        run("R6 fake from tpmpc", 6'h30, 1, 0, 0, 1, 6'h28, 6'h00);
        // R7: back to VME
        wr_cfg(16'h0100);
        @(negedge clk);
        chk("R7 vme idle", {10'h0, fc_cmd}, 16'h0007);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule